// File: doc/BRIEF.md
# Timer Trigger Output Mode Selector

This block drives the two trigger lines that a general-purpose timer hands to other blocks, such as a converter that samples on a timer event. A primary line and a secondary line each take their source from a group of timer events that arrive as inputs. These events are the counter reset pulse, the counter enable level, the update event, the channel 1 compare-match flag, and six compare reference levels, numbered 1 to 6. The counter, the prescaler and the compare channels sit outside this block.

A single control word holds one mode field for each line. The primary line can choose between the four event sources and the first four reference levels. The secondary line has a 16-entry table. It adds references 5 and 6, either-edge pulses, and modes that OR an edge on one reference with an edge on another. Edge modes produce a pulse one clock long for each qualifying edge. Both lines are registered.

The parameter `HAS_SEC` chooses whether the secondary line is built. When it is absent, its field cannot be written and reads back as zero, so software can probe for the feature by writing the field and reading it back. The periodic-sampling use case sets either field to 2 (update).

Top module: `trig_mode_sel`

## Requirements
- R1: While `rst_n` is low, `trig_pri` and `trig_sec` are low and `rd_data` reads zero. After reset, both mode fields are 0.
- R2: A write with `wr_en` high loads `wr_data[6:4]` into the primary mode field and `wr_data[23:20]` into the secondary mode field. The loaded values appear on `rd_data` from the next cycle. All other `rd_data` bits read 0.
- R3: Event modes are the same on both lines. Mode 0 follows `cnt_rst`, mode 1 follows `cnt_en`, mode 2 follows `upd_evt`, and mode 3 follows `cc1_match`.
- R4: In level modes, `oc_ref[k]` holds reference k+1. Modes 4 to 7 pass `oc_ref[0]` to `oc_ref[3]`, and secondary modes 8 and 9 pass `oc_ref[4]` and `oc_ref[5]`.
- R5: Secondary mode 10 gives a one-cycle pulse on either edge of `oc_ref[3]`. Mode 11 does the same for `oc_ref[5]`. A reference that does not change gives no pulse.
- R6: Secondary mode 12 pulses on a rise of `oc_ref[3]` or a rise of `oc_ref[5]`. Mode 13 pulses on a rise of `oc_ref[3]` or a fall of `oc_ref[5]`. Mode 14 pulses on a rise of `oc_ref[4]` or a rise of `oc_ref[5]`. Mode 15 pulses on a rise of `oc_ref[4]` or a fall of `oc_ref[5]`. An edge in the other direction, or a change on another reference, gives no pulse.
- R7: In combined modes, two qualifying edges on different cycles give two separate pulses.
- R8: With `HAS_SEC` = 0, writes to bits 23:20 have no effect, those bits read 0, and `trig_sec` stays low. The primary line still works.
- R9: The two lines are independent. Each can assert in the same cycle from its own source.
- R10: Each output changes exactly one cycle after the input condition it selects. An edge is detected by comparing each reference with its value on the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Control word write strobe |
| wr_data | input | 32 | Control word write value |
| rd_data | output | 32 | Control word read value |
| cnt_rst | input | 1 | Counter reset pulse |
| cnt_en | input | 1 | Counter enable level |
| upd_evt | input | 1 | Update event pulse |
| cc1_match | input | 1 | Channel 1 compare-match flag |
| oc_ref | input | 6 | Compare reference levels 1 to 6 |
| trig_pri | output | 1 | Primary trigger |
| trig_sec | output | 1 | Secondary trigger |

## Verification
Two functions can coincide in one cycle. One case is the two trigger lines asserting together from different sources. The bench provokes this by setting the primary line to mode 0 and the secondary line to mode 2, then raising counter reset and update in the same cycle; both outputs must be high one cycle later. The other case is a qualifying edge on both references of a combined mode arriving in the same cycle. This must merge into one pulse. By contrast, edges on separate cycles must give two pulses, and the bench checks this by counting the high cycles on `trig_sec` over a fixed window.

// File: rtl/trig_pkg.sv
`timescale 1ns/1ps
package trig_pkg;
  localparam int REG_W  = 32;
  localparam int PM_LSB = 4;
  localparam int PM_W   = 3;
  localparam int SM_LSB = 20;
  localparam int SM_W   = 4;
  localparam int NREF   = 6;

  typedef enum logic [3:0] {
    TM_CNT_RST  = 4'd0,
    TM_CNT_EN   = 4'd1,
    TM_UPDATE   = 4'd2,
    TM_CC1      = 4'd3,
    TM_LVL1     = 4'd4,
    TM_LVL2     = 4'd5,
    TM_LVL3     = 4'd6,
    TM_LVL4     = 4'd7,
    TM_LVL5     = 4'd8,
    TM_LVL6     = 4'd9,
    TM_ANY4     = 4'd10,
    TM_ANY6     = 4'd11,
    TM_R4_OR_R6 = 4'd12,
    TM_R4_OR_F6 = 4'd13,
    TM_R5_OR_R6 = 4'd14,
    TM_R5_OR_F6 = 4'd15
  } trig_mode_e;

  typedef struct packed {
    logic cnt_rst;
    logic cnt_en;
    logic upd;
    logic cc1;
  } tim_evt_t;
endpackage

// File: rtl/trig_ctrl_reg.sv
`timescale 1ns/1ps
module trig_ctrl_reg
  import trig_pkg::*;
#(
  parameter bit HAS_SEC = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  output logic [PM_W-1:0]  pmode,
  output logic [SM_W-1:0]  smode
);
  logic unused_wr_bits;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     pmode <= '0;
    else if (wr_en) pmode <= wr_data[PM_LSB +: PM_W];
  end

  generate
    if (HAS_SEC) begin : g_sec_field
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     smode <= '0;
        else if (wr_en) smode <= wr_data[SM_LSB +: SM_W];
      end
      assign unused_wr_bits = ^{wr_data[REG_W-1:SM_LSB+SM_W],
                                wr_data[SM_LSB-1:PM_LSB+PM_W],
                                wr_data[PM_LSB-1:0]};
    end else begin : g_sec_absent
      assign smode = '0;
      assign unused_wr_bits = ^{wr_data[REG_W-1:PM_LSB+PM_W],
                                wr_data[PM_LSB-1:0]};
    end
  endgenerate

  always_comb begin
    rd_data = '0;
    rd_data[PM_LSB +: PM_W] = pmode;
    rd_data[SM_LSB +: SM_W] = smode;
  end
endmodule

// File: rtl/trig_edge_det.sv
`timescale 1ns/1ps
module trig_edge_det #(
  parameter int N = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] lvl,
  output logic [N-1:0] rise,
  output logic [N-1:0] fall
);
  logic [N-1:0] lvl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl_q <= '0;
    else        lvl_q <= lvl;
  end

  for (genvar i = 0; i < N; i++) begin : g_bit
    assign rise[i] = lvl[i] & ~lvl_q[i];
    assign fall[i] = ~lvl[i] & lvl_q[i];
  end
endmodule

// File: rtl/trig_src_sel.sv
`timescale 1ns/1ps
module trig_src_sel
  import trig_pkg::*;
#(
  parameter int MODE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [MODE_W-1:0] mode,
  input  tim_evt_t          evt,
  input  logic [NREF-1:0]   lvl,
  input  logic [NREF-1:0]   rise,
  input  logic [NREF-1:0]   fall,
  output logic              trig
);
  trig_mode_e mode_e;
  logic       nxt;

  always_comb begin
    logic [3:0] m;
    m = '0;
    m[MODE_W-1:0] = mode;
    mode_e = trig_mode_e'(m);
  end

  always_comb begin
    unique case (mode_e)
      TM_CNT_RST:  nxt = evt.cnt_rst;
      TM_CNT_EN:   nxt = evt.cnt_en;
      TM_UPDATE:   nxt = evt.upd;
      TM_CC1:      nxt = evt.cc1;
      TM_LVL1:     nxt = lvl[0];
      TM_LVL2:     nxt = lvl[1];
      TM_LVL3:     nxt = lvl[2];
      TM_LVL4:     nxt = lvl[3];
      TM_LVL5:     nxt = lvl[4];
      TM_LVL6:     nxt = lvl[5];
      TM_ANY4:     nxt = rise[3] | fall[3];
      TM_ANY6:     nxt = rise[5] | fall[5];
      TM_R4_OR_R6: nxt = rise[3] | rise[5];
      TM_R4_OR_F6: nxt = rise[3] | fall[5];
      TM_R5_OR_R6: nxt = rise[4] | rise[5];
      TM_R5_OR_F6: nxt = rise[4] | fall[5];
      default:     nxt = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) trig <= 1'b0;
    else        trig <= nxt;
  end
endmodule

// File: rtl/trig_mode_sel.sv
`timescale 1ns/1ps
module trig_mode_sel
  import trig_pkg::*;
#(
  parameter bit HAS_SEC = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  input  logic             cnt_rst,
  input  logic             cnt_en,
  input  logic             upd_evt,
  input  logic             cc1_match,
  input  logic [NREF-1:0]  oc_ref,
  output logic             trig_pri,
  output logic             trig_sec
);
  logic [PM_W-1:0] pmode;
  logic [SM_W-1:0] smode;
  tim_evt_t        evt;

  assign evt = '{cnt_rst: cnt_rst, cnt_en: cnt_en, upd: upd_evt, cc1: cc1_match};

  trig_ctrl_reg #(.HAS_SEC(HAS_SEC)) u_reg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .pmode(pmode), .smode(smode)
  );

  trig_src_sel #(.MODE_W(PM_W)) u_pri (
    .clk(clk), .rst_n(rst_n), .mode(pmode), .evt(evt), .lvl(oc_ref),
    .rise('0), .fall('0), .trig(trig_pri)
  );

  generate
    if (HAS_SEC) begin : g_sec
      logic [NREF-1:0] rise, fall;

      trig_edge_det #(.N(NREF)) u_edge (
        .clk(clk), .rst_n(rst_n), .lvl(oc_ref), .rise(rise), .fall(fall)
      );

      trig_src_sel #(.MODE_W(SM_W)) u_sec (
        .clk(clk), .rst_n(rst_n), .mode(smode), .evt(evt), .lvl(oc_ref),
        .rise(rise), .fall(fall), .trig(trig_sec)
      );
    end else begin : g_no_sec
      logic unused_smode;
      assign unused_smode = ^smode;
      assign trig_sec = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/trig_mode_sel_chk.sv
`timescale 1ns/1ps
module trig_mode_sel_chk
  import trig_pkg::*;
#(
  parameter bit HAS_SEC = 1'b1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [REG_W-1:0] wr_data,
  input logic [REG_W-1:0] rd_data,
  input logic             upd_evt,
  input logic [NREF-1:0]  oc_ref,
  input logic             trig_pri,
  input logic             trig_sec
);
  logic ref6_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ref6_q <= 1'b0;
    else        ref6_q <= oc_ref[5];
  end

  a_r2_rsvd_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[REG_W-1:SM_LSB+SM_W] == '0) && (rd_data[SM_LSB-1:PM_LSB+PM_W] == '0)
    && (rd_data[PM_LSB-1:0] == '0));

  a_r2_pri_write: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> rd_data[PM_LSB +: PM_W] == $past(wr_data[PM_LSB +: PM_W]));

  a_r3_update: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[PM_LSB +: PM_W] == 3'd2) |=> trig_pri == $past(upd_evt));

  a_r4_level1: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[PM_LSB +: PM_W] == 3'd4) |=> trig_pri == $past(oc_ref[0]));

  generate
    if (HAS_SEC) begin : g_sec_chk
      a_r5_any6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data[SM_LSB +: SM_W] == 4'd11) |=> trig_sec == ($past(oc_ref[5]) != $past(ref6_q)));
    end else begin : g_abs_chk
      a_r8_absent: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data[SM_LSB +: SM_W] == '0) && !trig_sec);
    end
  endgenerate
endmodule

bind trig_mode_sel trig_mode_sel_chk #(.HAS_SEC(HAS_SEC)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
  .rd_data(rd_data), .upd_evt(upd_evt), .oc_ref(oc_ref),
  .trig_pri(trig_pri), .trig_sec(trig_sec)
);

// File: tb/sim_trig_mode_sel.sv
`timescale 1ns/1ps
module sim_trig_mode_sel;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [9:0]  ins = '0;
  logic [31:0] rd0, rd1;
  logic        tp0, ts0, tp1, ts1;
  int          n_chk = 0;
  int          n_fail = 0;

  always #2.5 clk = ~clk;

  // ins: [9] cnt_rst [8] cnt_en [7] upd [6] cc1 [5:0] oc_ref
  trig_mode_sel #(.HAS_SEC(1'b1)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd0),
    .cnt_rst(ins[9]), .cnt_en(ins[8]), .upd_evt(ins[7]), .cc1_match(ins[6]),
    .oc_ref(ins[5:0]), .trig_pri(tp0), .trig_sec(ts0)
  );

  trig_mode_sel #(.HAS_SEC(1'b0)) u1 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd1),
    .cnt_rst(ins[9]), .cnt_en(ins[8]), .upd_evt(ins[7]), .cc1_match(ins[6]),
    .oc_ref(ins[5:0]), .trig_pri(tp1), .trig_sec(ts1)
  );

  // {tag, pmode, smode, stateA, stateB, exp_pri, exp_sec}
  localparam int NV = 15;
  localparam logic [32:0] VEC [NV] = '{
    {4'd3, 3'd0, 4'd2,  10'b0000000000, 10'b1010000000, 2'b11},
    {4'd3, 3'd1, 4'd3,  10'b0000000000, 10'b0100000000, 2'b10},
    {4'd3, 3'd3, 4'd1,  10'b0000000000, 10'b0001000000, 2'b10},
    {4'd4, 3'd4, 4'd8,  10'b0000000000, 10'b0000010001, 2'b11},
    {4'd4, 3'd7, 4'd9,  10'b0000000000, 10'b0000001000, 2'b10},
    {4'd4, 3'd5, 4'd9,  10'b0000000000, 10'b0000100000, 2'b01},
    {4'd5, 3'd6, 4'd10, 10'b0000001000, 10'b0000000000, 2'b01},
    {4'd5, 3'd0, 4'd10, 10'b0000001000, 10'b0000001000, 2'b00},
    {4'd5, 3'd0, 4'd11, 10'b0000100000, 10'b0000000000, 2'b01},
    {4'd6, 3'd0, 4'd12, 10'b0000000000, 10'b0000100000, 2'b01},
    {4'd6, 3'd0, 4'd13, 10'b0000100000, 10'b0000000000, 2'b01},
    {4'd6, 3'd0, 4'd13, 10'b0000000000, 10'b0000100000, 2'b00},
    {4'd6, 3'd0, 4'd14, 10'b0000000000, 10'b0000010000, 2'b01},
    {4'd6, 3'd0, 4'd15, 10'b0000000000, 10'b0000001000, 2'b00},
    {4'd6, 3'd0, 4'd12, 10'b0000001000, 10'b0000000000, 2'b00}
  };

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [31:0] d);
    wr_en = 1'b1;
    wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    wr_data = '0;
  endtask

  function automatic logic [31:0] modes(logic [2:0] p, logic [3:0] s);
    logic [31:0] w;
    w = '0;
    w[6:4] = p;
    w[23:20] = s;
    return w;
  endfunction

  initial begin
    #2_000_000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 rd_data in reset", rd0, 32'h0);
    check("R1 trig_pri in reset", {31'b0, tp0}, 32'h0);
    check("R1 trig_sec in reset", {31'b0, ts0}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 modes zero after reset", rd0, 32'h0);

    // R2 field placement and reserved bits
    wr(32'hFFFF_FFFF);
    check("R2 readback all-ones write", rd0, 32'h00F0_0070);
    check("R8 absent field reads zero", rd1, 32'h0000_0070);
    wr(modes(3'd5, 4'd9));
    check("R2 readback fields", rd0, 32'h0090_0050);

    // table walk: R3 R4 R5 R6 R9
    for (int i = 0; i < NV; i++) begin
      logic [32:0] v;
      string tg;
      v = VEC[i];
      tg = $sformatf("R%0d vec%0d", v[32:29], i);
      wr(modes(v[28:26], v[25:22]));
      ins = v[21:12];
      @(negedge clk);
      ins = v[11:2];
      @(negedge clk);
      check({tg, " pri"}, {31'b0, tp0}, {31'b0, v[1]});
      check({tg, " sec"}, {31'b0, ts0}, {31'b0, v[0]});
    end

    // R10 timing of an update pulse on the primary line
    ins = '0;
    wr(modes(3'd2, 4'd0));
    @(negedge clk);
    ins[7] = 1'b1;
    #1;
    check("R10 before edge", {31'b0, tp0}, 32'h0);
    @(negedge clk);
    ins[7] = 1'b0;
    check("R10 one cycle later", {31'b0, tp0}, 32'h1);
    @(negedge clk);
    check("R10 pulse ends", {31'b0, tp0}, 32'h0);

    // R6 same-cycle edges merge into one pulse
    wr(modes(3'd0, 4'd12));
    ins = 10'b0000101000;
    @(negedge clk);
    check("R6 merged edges pulse", {31'b0, ts0}, 32'h1);
    @(negedge clk);
    check("R6 merged edges single", {31'b0, ts0}, 32'h0);

    // R7 separate edges give separate pulses
    ins = '0;
    @(negedge clk);
    @(negedge clk);
    begin
      int cnt;
      cnt = 0;
      ins[3] = 1'b1;
      for (int k = 0; k < 6; k++) begin
        if (k == 2) ins[5] = 1'b1;
        @(negedge clk);
        if (ts0) cnt++;
      end
      check("R7 pulse count", cnt, 2);
    end

    // R8 absent secondary stays low, primary still works
    ins = '0;
    wr(modes(3'd7, 4'd0));
    for (int k = 0; k < 4; k++) begin
      ins = (k % 2 == 0) ? 10'b1000101000 : 10'b0000000000;
      @(negedge clk);
      check("R8 absent trig_sec low", {31'b0, ts1}, 32'h0);
      check("R8 absent trig_pri level", {31'b0, tp1}, {31'b0, ins[3]});
    end

    // R1 reset mid-run clears a held output
    ins = 10'b0100000000;
    wr(modes(3'd1, 4'd1));
    @(negedge clk);
    check("R1 pre-reset level high", {31'b0, tp0}, 32'h1);
    #1 rst_n = 1'b0;
    #1;
    check("R1 async clear pri", {31'b0, tp0}, 32'h0);
    check("R1 async clear sec", {31'b0, ts0}, 32'h0);
    check("R1 async clear reg", rd0, 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    ins = '0;
    @(negedge clk);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule